// File: doc/BRIEF.md
# Host Memory Address Target Decoder

This block sits beside the processor bus and decides, for every memory request, which agent owns the address. Each request is 36 bits wide and covers a 64 GB space. The result is one of four targets: local DRAM, one of sixteen interrupt-controller units, the peripheral bus, or nobody. Software programs the configuration through a small write port. The registers hold a top-of-memory mark, two gap windows, a system-management window and a control word. The decode itself is pure logic. It is captured in a flop, so the answer appears on the clock edge after the request.

The rules overlap, so priority decides the result. A request tagged as system-management traffic is checked first against its own window, and only such a request is checked there. The interrupt-controller slots at FEC00000h–FEC0FFFFh come next. The rest of that megabyte is reserved. Next is the firmware/high region FED00000h–FFDFFFFFh, which can be protected from the gaps. Then come the two gap windows, which may sit anywhere, including above 4 GB. Last comes the top-of-memory comparison. All window fields and the top-of-memory mark are in 1 MB units and are compared against address bits 35:20.

Top module: `host_mem_decoder`

## Requirements
- R1: After reset the response outputs are all zero. Top of memory resets to 0x0800 (2 GB). The control word resets to zero, so every window is disabled.
- R2: Target codes are 0 = none, 1 = local memory, 2 = interrupt controller, 3 = peripheral bus. A request presented with `req_valid_i` high at a rising edge is answered on the outputs from that edge onward, with `rsp_valid_o` = 1. A cycle without a request gives `rsp_valid_o` = 0, target 0 and unit 0.
- R3: Any address in FEC00000h–FEC0FFFFh, unless claimed by R9, gives target 2 with `rsp_unit_o` equal to address bits 15:12. Every other target reports unit 0.
- R4: Addresses FEC10000h–FECFFFFFh, unless claimed by R9, give target 0.
- R5: An address in FED00000h–FFDFFFFFh gives target 3 if bits 35:20 are at or above top of memory. It also gives target 3 if control bit 0 (high-region protect) is clear and the address lies in an enabled gap. Otherwise it gives target 1.
- R6: Outside the fixed windows, an address whose bits 35:20 lie within [gap base, gap limit] inclusive gives target 3 when control bit 1 is set. A base above the limit matches nothing.
- R7: The high gap behaves like R6, using its own base and limit and control bit 2.
- R8: Any other address gives target 3 when bits 35:20 are at or above top of memory, and target 1 otherwise.
- R9: With `req_smm_i` set, control bit 3 set and bits 35:20 within [SMM base, SMM limit], the target is 1, overriding all other rules. With `req_smm_i` clear, the SMM window has no effect.
- R10: Register indices are 0 top, 1/2 gap base/limit, 3/4 high-gap base/limit, 5/6 SMM base/limit, 7 control (bits 3:0). A write is used by any request presented at a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register index |
| cfg_wdata_i | input | 16 | Configuration write data |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 36 | Request byte address |
| req_smm_i | input | 1 | Request issued in system-management mode |
| rsp_valid_o | output | 1 | Registered response valid |
| rsp_tgt_o | output | 2 | Registered target code |
| rsp_unit_o | output | 4 | Interrupt-controller unit index |

## Verification
The hardest situations to reach are collisions between rules: the SMM window laid over the interrupt-controller slots, a gap covering the high region while protection is on or off, and top of memory dropping below FED00000h. The bench programs six configurations built to cause these overlaps. Under each one it sweeps the megabyte index in coarse strides. It then walks every megabyte from FE0h to FFFh at several offsets and every unit slot, each with the SMM flag both clear and set. A rewrite of top of memory followed at once by a request at the boundary block shows that a write reaches the next decode.

// File: rtl/hmd_pkg.sv
package hmd_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_MEM  = 2'd1,
    TGT_APIC = 2'd2,
    TGT_PCI  = 2'd3
  } tgt_e;

  // register indices; pairs of base/limit are laid out so range r uses 1+2r / 2+2r
  localparam int F_TOM    = 0;
  localparam int F_GAP_B  = 1;
  localparam int F_GAP_L  = 2;
  localparam int F_HGAP_B = 3;
  localparam int F_HGAP_L = 4;
  localparam int F_SMM_B  = 5;
  localparam int F_SMM_L  = 6;
  localparam int N_FLD    = 7;
  localparam int REG_CTRL = 7;

  // control bits; range r is enabled by bit C_GAP_EN+r
  localparam int C_HI_EN   = 0;
  localparam int C_GAP_EN  = 1;
  localparam int C_HGAP_EN = 2;
  localparam int C_SMM_EN  = 3;
  localparam int CTRL_W    = 4;

  localparam int RNG_GAP  = 0;
  localparam int RNG_HGAP = 1;
  localparam int RNG_SMM  = 2;
  localparam int N_RNG    = 3;

  localparam logic [31:0] APIC_BASE = 32'hFEC0_0000;
  localparam logic [31:0] HI_LO     = 32'hFED0_0000;
  localparam logic [31:0] HI_HI     = 32'hFFDF_FFFF;
  localparam int UNIT_LSB     = 12;
  localparam int UNIT_W       = 4;
  localparam int APIC_BLK_LSB = 20;

endpackage

// File: rtl/hmd_range_chk.sv
module hmd_range_chk #(
  parameter int W = 16
) (
  input  logic         en_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] val_i,
  output logic         hit_o
);

  assign hit_o = en_i && (val_i >= lo_i) && (val_i <= hi_i);

endmodule

// File: rtl/hmd_cfg_regs.sv
module hmd_cfg_regs
  import hmd_pkg::*;
#(
  parameter int            FW      = 16,
  parameter int            AW      = 3,
  parameter logic [FW-1:0] RST_TOM = 'h800
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [FW-1:0]            wdata_i,
  output logic [N_FLD-1:0][FW-1:0] fld_o,
  output logic [CTRL_W-1:0]        ctrl_o
);

  logic [N_FLD-1:0][FW-1:0] fld_q;
  logic [CTRL_W-1:0]        ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_FLD; i++) fld_q[i] <= (i == F_TOM) ? RST_TOM : '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      if (addr_i == AW'(REG_CTRL)) begin
        ctrl_q <= wdata_i[CTRL_W-1:0];
      end else begin
        for (int i = 0; i < N_FLD; i++) begin
          if (addr_i == AW'(i)) fld_q[i] <= wdata_i;
        end
      end
    end
  end

  assign fld_o  = fld_q;
  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/hmd_classify.sv
module hmd_classify
  import hmd_pkg::*;
#(
  parameter int AW = 36,
  parameter int GL = 20
) (
  input  logic [AW-1:0]     addr_i,
  input  logic              smm_i,
  input  logic [AW-GL-1:0]  tom_i,
  input  logic              hi_en_i,
  input  logic [N_RNG-1:0]  rng_hit_i,
  output tgt_e              tgt_o,
  output logic [UNIT_W-1:0] unit_o
);

  localparam int            FW      = AW - GL;
  localparam int            WIN_LSB = UNIT_LSB + UNIT_W;
  localparam logic [AW-1:0] APIC_A  = AW'(APIC_BASE);
  localparam logic [AW-1:0] HI_LO_A = AW'(HI_LO);
  localparam logic [AW-1:0] HI_HI_A = AW'(HI_HI);

  logic [FW-1:0] blk;
  logic smm_hit, apic_hit, rsvd_hit, hi_hit, gap_hit, above_tom;

  assign blk       = addr_i[AW-1:GL];
  assign smm_hit   = smm_i && rng_hit_i[RNG_SMM];
  assign apic_hit  = (addr_i >> WIN_LSB) == (APIC_A >> WIN_LSB);
  assign rsvd_hit  = !apic_hit && ((addr_i >> APIC_BLK_LSB) == (APIC_A >> APIC_BLK_LSB));
  assign hi_hit    = (addr_i >= HI_LO_A) && (addr_i <= HI_HI_A);
  assign gap_hit   = rng_hit_i[RNG_GAP] || rng_hit_i[RNG_HGAP];
  assign above_tom = blk >= tom_i;

  always_comb begin
    tgt_o  = TGT_PCI;
    unit_o = '0;
    if (smm_hit) begin
      tgt_o = TGT_MEM;
    end else if (apic_hit) begin
      tgt_o  = TGT_APIC;
      unit_o = addr_i[UNIT_LSB +: UNIT_W];
    end else if (rsvd_hit) begin
      tgt_o = TGT_NONE;
    end else if (hi_hit) begin
      // protect bit shields the high region from the gaps, not from top of memory
      tgt_o = (above_tom || (!hi_en_i && gap_hit)) ? TGT_PCI : TGT_MEM;
    end else begin
      tgt_o = (gap_hit || above_tom) ? TGT_PCI : TGT_MEM;
    end
  end

endmodule

// File: rtl/host_mem_decoder.sv
module host_mem_decoder
  import hmd_pkg::*;
#(
  parameter int                            ADDR_W   = 36,
  parameter int                            GRAN_LSB = 20,
  parameter int                            CFG_AW   = 3,
  parameter logic [ADDR_W-GRAN_LSB-1:0]    RST_TOM  = 'h800
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [CFG_AW-1:0]            cfg_addr_i,
  input  logic [ADDR_W-GRAN_LSB-1:0]   cfg_wdata_i,
  input  logic                         req_valid_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  logic                         req_smm_i,
  output logic                         rsp_valid_o,
  output logic [1:0]                   rsp_tgt_o,
  output logic [UNIT_W-1:0]            rsp_unit_o
);

  localparam int FW = ADDR_W - GRAN_LSB;

  logic [N_FLD-1:0][FW-1:0] cfg_fld;
  logic [CTRL_W-1:0]        cfg_ctrl;
  logic [N_RNG-1:0]         rng_hit;
  tgt_e                     tgt_c;
  logic [UNIT_W-1:0]        unit_c;

  hmd_cfg_regs #(
    .FW      (FW),
    .AW      (CFG_AW),
    .RST_TOM (RST_TOM)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .fld_o   (cfg_fld),
    .ctrl_o  (cfg_ctrl)
  );

  for (genvar r = 0; r < N_RNG; r++) begin : g_rng
    hmd_range_chk #(
      .W (FW)
    ) u_rng (
      .en_i  (cfg_ctrl[C_GAP_EN + r]),
      .lo_i  (cfg_fld[F_GAP_B + 2*r]),
      .hi_i  (cfg_fld[F_GAP_L + 2*r]),
      .val_i (req_addr_i[ADDR_W-1:GRAN_LSB]),
      .hit_o (rng_hit[r])
    );
  end

  hmd_classify #(
    .AW (ADDR_W),
    .GL (GRAN_LSB)
  ) u_cls (
    .addr_i    (req_addr_i),
    .smm_i     (req_smm_i),
    .tom_i     (cfg_fld[F_TOM]),
    .hi_en_i   (cfg_ctrl[C_HI_EN]),
    .rng_hit_i (rng_hit),
    .tgt_o     (tgt_c),
    .unit_o    (unit_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_tgt_o   <= TGT_NONE;
      rsp_unit_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_tgt_o   <= req_valid_i ? tgt_c : TGT_NONE;
      rsp_unit_o  <= req_valid_i ? unit_c : '0;
    end
  end

endmodule

// File: rtl/hmd_chk.sv
module hmd_chk #(
  parameter int ADDR_W   = 36,
  parameter int GRAN_LSB = 20
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_valid_i,
  input logic [ADDR_W-1:0]          req_addr_i,
  input logic                       req_smm_i,
  input logic                       rsp_valid_o,
  input logic [1:0]                 rsp_tgt_o,
  input logic [3:0]                 rsp_unit_o,
  input logic                       smm_win_i,
  input logic [ADDR_W-GRAN_LSB-1:0] tom_i,
  input logic [3:0]                 ctrl_i
);

  logic in_apic, in_rsvd, in_high, above4g;
  assign in_apic = req_addr_i[ADDR_W-1:16] == (ADDR_W-16)'('h0FEC0);
  assign in_rsvd = (req_addr_i[ADDR_W-1:20] == (ADDR_W-20)'('h0FEC)) && (req_addr_i[19:16] != 4'h0);
  assign in_high = (req_addr_i >= ADDR_W'(36'h0_FED0_0000)) && (req_addr_i <= ADDR_W'(36'h0_FFDF_FFFF));
  assign above4g = req_addr_i[ADDR_W-1:32] != '0;

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && rsp_tgt_o == 2'd0 && rsp_unit_o == 4'd0));

  p_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_apic_unit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_smm_i && in_apic) |=>
      (rsp_tgt_o == 2'd2 && rsp_unit_o == $past(req_addr_i[15:12])));

  p_unit_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_tgt_o != 2'd2) |-> (rsp_unit_o == 4'd0));

  p_rsvd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_smm_i && in_rsvd) |=> (rsp_tgt_o == 2'd0));

  p_high_above_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_smm_i && in_high && req_addr_i[ADDR_W-1:GRAN_LSB] >= tom_i)
      |=> (rsp_tgt_o == 2'd3));

  p_tom_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_smm_i && above4g && !ctrl_i[1] && !ctrl_i[2]
     && req_addr_i[ADDR_W-1:GRAN_LSB] >= tom_i) |=> (rsp_tgt_o == 2'd3));

  p_smm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_smm_i && smm_win_i) |=> (rsp_tgt_o == 2'd1));

endmodule

bind host_mem_decoder hmd_chk #(
  .ADDR_W   (ADDR_W),
  .GRAN_LSB (GRAN_LSB)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_addr_i  (req_addr_i),
  .req_smm_i   (req_smm_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_tgt_o   (rsp_tgt_o),
  .rsp_unit_o  (rsp_unit_o),
  .smm_win_i   (rng_hit[hmd_pkg::RNG_SMM]),
  .tom_i       (cfg_fld[hmd_pkg::F_TOM]),
  .ctrl_i      (cfg_ctrl)
);

// File: tb/host_mem_decoder_test.sv
module host_mem_decoder_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [35:0] req_addr = '0;
  logic        req_smm = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_tgt;
  logic [3:0]  rsp_unit;

  int total = 0;
  int bad = 0;
  logic [15:0] m_fld [7];
  logic [3:0]  m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_mem_decoder uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we),
    .cfg_addr_i  (cfg_addr),
    .cfg_wdata_i (cfg_wdata),
    .req_valid_i (req_valid),
    .req_addr_i  (req_addr),
    .req_smm_i   (req_smm),
    .rsp_valid_o (rsp_valid),
    .rsp_tgt_o   (rsp_tgt),
    .rsp_unit_o  (rsp_unit)
  );

  function automatic logic in_rng(input int r, input logic [15:0] b);
    return m_ctrl[1+r] && (b >= m_fld[1+2*r]) && (b <= m_fld[2+2*r]);
  endfunction

  task automatic model(input logic [35:0] a, input logic smm,
                       output logic [1:0] t, output logic [3:0] u, output string tag);
    logic [15:0] b;
    b = a[35:20];
    u = 4'd0;
    if (smm && in_rng(2, b)) begin
      t = 2'd1; tag = "R9";
    end else if (a[35:16] == 20'h0FEC0) begin
      t = 2'd2; u = a[15:12]; tag = "R3";
    end else if (a[35:20] == 16'h0FEC) begin
      t = 2'd0; tag = "R4";
    end else if (a >= 36'h0_FED0_0000 && a <= 36'h0_FFDF_FFFF) begin
      tag = "R5";
      if (b >= m_fld[0]) t = 2'd3;
      else if (!m_ctrl[0] && (in_rng(0, b) || in_rng(1, b))) t = 2'd3;
      else t = 2'd1;
    end else if (in_rng(0, b)) begin
      t = 2'd3; tag = "R6";
    end else if (in_rng(1, b)) begin
      t = 2'd3; tag = "R7";
    end else begin
      t = (b >= m_fld[0]) ? 2'd3 : 2'd1; tag = "R8";
    end
    if (!smm && in_rng(2, b)) tag = {tag, "+R9 flag clear"};
  endtask

  task automatic wr(input int idx, input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = idx[2:0]; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx == 7) m_ctrl = v[3:0];
    else m_fld[idx] = v;
  endtask

  task automatic req(input logic [35:0] a, input logic smm, input string extra);
    logic [1:0] et;
    logic [3:0] eu;
    string tag;
    model(a, smm, et, eu, tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_smm = smm;
    @(negedge clk);
    total++;
    if (rsp_valid !== 1'b1 || rsp_tgt !== et || rsp_unit !== eu) begin
      bad++;
      $display("FAIL %s%s R2 addr=%h smm=%0d: got v=%0d tgt=%0d unit=%0d exp v=1 tgt=%0d unit=%0d",
               tag, extra, a, smm, rsp_valid, rsp_tgt, rsp_unit, et, eu);
    end
    req_valid = 1'b0;
  endtask

  task automatic idle(input logic [35:0] a);
    @(negedge clk);
    req_valid = 1'b0; req_addr = a; req_smm = 1'b1;
    @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0 || rsp_tgt !== 2'd0 || rsp_unit !== 4'd0) begin
      bad++;
      $display("FAIL R2 idle: got v=%0d tgt=%0d unit=%0d exp v=0 tgt=0 unit=0",
               rsp_valid, rsp_tgt, rsp_unit);
    end
  endtask

  task automatic sweep();
    for (int b = 0; b < 65536; b += 97) begin
      for (int s = 0; s < 2; s++) begin
        logic [31:0] lo;
        lo = b * 32'h1357;
        req({b[15:0], lo[19:0]}, s[0], "");
      end
    end
    for (int b = 'hFE0; b <= 'hFFF; b++) begin
      for (int j = 0; j < 4; j++) begin
        for (int s = 0; s < 2; s++) begin
          logic [31:0] lo;
          lo = j * 32'h44444;
          req({b[15:0], lo[19:0]}, s[0], "");
        end
      end
    end
    for (int k = 0; k < 16; k++) begin
      for (int s = 0; s < 2; s++) begin
        logic [11:0] off;
        off = 12'(k * 4);
        req({20'h0FEC0, k[3:0], off}, s[0], " R3 slot");
      end
    end
    idle(36'h0_FEC0_3000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) m_fld[i] = 16'h0;
    m_fld[0] = 16'h0800;
    m_ctrl   = 4'h0;

    repeat (3) @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0 || rsp_tgt !== 2'd0 || rsp_unit !== 4'd0) begin
      bad++;
      $display("FAIL R1 in reset: got v=%0d tgt=%0d unit=%0d exp 0 0 0", rsp_valid, rsp_tgt, rsp_unit);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0 || rsp_tgt !== 2'd0 || rsp_unit !== 4'd0) begin
      bad++;
      $display("FAIL R1 after reset: got v=%0d tgt=%0d unit=%0d exp 0 0 0", rsp_valid, rsp_tgt, rsp_unit);
    end
    req(36'h0_8000_0000, 1'b0, " R1 reset tom");
    req(36'h0_7FF0_0000, 1'b0, " R1 reset tom");
    req(36'h0_7FF0_0000, 1'b1, " R1 smm disabled");
    idle(36'h0_0000_1000);

    // config 0: reset values
    sweep();

    // config 1: tom at 4 GB, low gap, high gap above 4 GB, smm window low
    wr(0, 16'h1000);
    wr(1, 16'h0300); wr(2, 16'h03FF);
    wr(3, 16'h1400); wr(4, 16'h17FF);
    wr(5, 16'h00A0); wr(6, 16'h00BF);
    wr(7, 16'b1110);
    req(36'h0_3000_0000, 1'b0, " R6 base edge");
    req(36'h0_3FFF_FFFF, 1'b0, " R6 limit edge");
    req(36'h0_4000_0000, 1'b0, " R6 past limit");
    req(36'h1_4000_0000, 1'b0, " R7 base edge");
    req(36'h1_8000_0000, 1'b0, " R7 past limit");
    sweep();

    // config 2: gap covering high region, protect on
    wr(0, 16'h2000);
    wr(1, 16'h0FE0); wr(2, 16'h0FFF);
    wr(7, 16'b1111);
    sweep();

    // config 3: protect off, smm window laid over the controller slots
    wr(0, 16'h4000);
    wr(1, 16'h0FF0); wr(2, 16'h0FFF);
    wr(5, 16'h0FE0); wr(6, 16'h0FFF);
    wr(7, 16'b1010);
    sweep();

    // config 4: tom below the high region
    wr(0, 16'h0F00);
    wr(7, 16'b0001);
    sweep();

    // config 5: empty gap (base above limit), single-block high gap at top
    wr(0, 16'hFFFF);
    wr(1, 16'h0500); wr(2, 16'h0400);
    wr(3, 16'hFFFF); wr(4, 16'hFFFF);
    wr(5, 16'h0000); wr(6, 16'hFFFF);
    wr(7, 16'b1111);
    req(36'h0_4500_0000, 1'b0, " R6 empty gap");
    req(36'hF_FFF0_0000, 1'b0, " R7 single block");
    req(36'hF_FFE0_0000, 1'b0, " R8 below tom");
    sweep();

    // R10: a write is seen by the very next request
    wr(7, 16'b0000);
    wr(0, 16'h0100);
    req(36'h0_1000_0000, 1'b0, " R10 tom=0100");
    wr(0, 16'h0101);
    req(36'h0_1000_0000, 1'b0, " R10 tom=0101");
    wr(1, 16'h0100); wr(2, 16'h0100); wr(7, 16'b0010);
    req(36'h0_1000_0000, 1'b0, " R10 gap enabled");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule